// File: doc/BRIEF.md
# Bus-Attached Arithmetic Unit with Branch Condition Flag

This block is the arithmetic unit of a small single-bus datapath. Two operand registers, A and B, take their values from the shared bus, each under its own load strobe. A two-bit function code picks one of four operations on the stored operands: sum, difference, bitwise NAND, or increment of A. The result drives the bus only when the drive enable is high. The bus drive is shown as a data/enable pair instead of a tri-state net.

A second path makes branch decisions. A combinational comparator watches whatever value is on the bus. During a conditional branch, the controller puts A−B there. A select input picks the test: the comparator reports either "A less than B" (the value is negative) or "A greater than B" (the value is positive and non-zero). A one-bit flag register captures the comparator output when the flag load strobe is high, and the controller's sequencer then reads it.

All arithmetic wraps modulo 2^WIDTH. Signed overflow of the subtraction is not detected, and the tests read only the sign and zero state of the bus value.

Top module: `alu_cmp_unit`

## Requirements
- R1: Function code 2'b00 gives result = A + B, modulo 2^WIDTH.
- R2: Function code 2'b01 gives result = A − B, modulo 2^WIDTH.
- R3: Function code 2'b10 gives result = ~(A & B), bit by bit.
- R4: Function code 2'b11 gives result = A + 1, modulo 2^WIDTH. The value held in B has no effect on it.
- R5: On a rising clock edge with ld_a high, A takes bus_in. On a rising clock edge with ld_b high, B takes bus_in. An operand register whose strobe is low keeps its value.
- R6: With drive_en high, bus_out equals result and bus_out_en is 1. With drive_en low, bus_out is all zeros and bus_out_en is 0.
- R7: With cmp_sel = 0 (less-than test), the comparator output is 1 exactly when bit WIDTH−1 of bus_in is 1.
- R8: With cmp_sel = 1 (greater-than test), the comparator output is 1 exactly when bit WIDTH−1 of bus_in is 0 and bus_in is not zero. A zero bus gives 0 for both tests.
- R9: On a rising clock edge with ld_flag high, cond_flag takes the comparator output formed from bus_in and cmp_sel. With ld_flag low, cond_flag holds its value whatever bus_in and cmp_sel do. The comparator reads the bus, not the operand registers.
- R10: A synchronous reset (rst high at a rising edge) clears cond_flag, A and B to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | WIDTH | Current value of the shared bus |
| ld_a | input | 1 | Load A from the bus |
| ld_b | input | 1 | Load B from the bus |
| ld_flag | input | 1 | Capture the comparator output into cond_flag |
| func_sel | input | 2 | Operation: 00 sum, 01 difference, 10 NAND, 11 A+1 |
| cmp_sel | input | 1 | Test select: 0 less-than, 1 greater-than |
| drive_en | input | 1 | Put the result on the bus |
| result | output | WIDTH | Combinational result of the operation |
| bus_out | output | WIDTH | Bus drive data, zero when not driving |
| bus_out_en | output | 1 | Bus drive enable |
| cond_flag | output | 1 | Captured branch condition |

## Verification
The bench builds the unit with the default WIDTH of 32. This brings the real sign-bit boundaries within reach: 32'h8000_0000 against 32'h7FFF_FFFF, all-ones operands that wrap on sum and increment, and differences of opposite-signed operands that overflow but are still judged only by bit 31. The bench closes the loop by feeding bus_out back into bus_in while drive_en is high. In that way the flag is set from a real A−B difference on the bus, and also from values forced on the bus directly.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;

  localparam int FN_W = 2;

  typedef enum logic [FN_W-1:0] {
    FN_SUM  = 2'b00,
    FN_DIFF = 2'b01,
    FN_NAND = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;

  localparam int OPERAND_CNT = 2;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;

endpackage

// File: rtl/alu_operand_reg.sv
module alu_operand_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  alu_fn_e          fn,
  output logic [WIDTH-1:0] y
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] f_sum(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] z);
    return x + z;
  endfunction

  function automatic logic [WIDTH-1:0] f_diff(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] z);
    return x + (~z) + ONE;
  endfunction

  function automatic logic [WIDTH-1:0] f_nand(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] z);
    return ~(x & z);
  endfunction

  function automatic logic [WIDTH-1:0] f_inc(input logic [WIDTH-1:0] x);
    return x + ONE;
  endfunction

  always_comb begin
    unique case (fn)
      FN_SUM:  y = f_sum(opa, opb);
      FN_DIFF: y = f_diff(opa, opb);
      FN_NAND: y = f_nand(opa, opb);
      FN_INC:  y = f_inc(opa);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/bus_cmp.sv
module bus_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] bus_val,
  input  logic             sel_gt,
  output logic             lt_hit,
  output logic             gt_hit,
  output logic             cond
);

  localparam int SIGN_BIT = WIDTH - 1;

  logic is_zero;

  assign is_zero = (bus_val == '0);
  assign lt_hit  = bus_val[SIGN_BIT];
  assign gt_hit  = ~bus_val[SIGN_BIT] & ~is_zero;
  assign cond    = sel_gt ? gt_hit : lt_hit;

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
  import alu_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             ld_a,
  input  logic             ld_b,
  input  logic             ld_flag,
  input  logic [1:0]       func_sel,
  input  logic             cmp_sel,
  input  logic             drive_en,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_out_en,
  output logic             cond_flag
);

  logic [OPERAND_CNT-1:0] op_load;
  logic [WIDTH-1:0]       op_q [OPERAND_CNT];
  logic [WIDTH-1:0]       op_a;
  logic [WIDTH-1:0]       op_b;
  logic                   cmp_live;
  logic                   lt_hit;
  logic                   gt_hit;

  assign op_load[IDX_A] = ld_a;
  assign op_load[IDX_B] = ld_b;

  for (genvar gi = 0; gi < OPERAND_CNT; gi++) begin : g_opreg
    alu_operand_reg #(.WIDTH(WIDTH)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (op_load[gi]),
      .d    (bus_in),
      .q    (op_q[gi])
    );
  end

  assign op_a = op_q[IDX_A];
  assign op_b = op_q[IDX_B];

  alu_core #(.WIDTH(WIDTH)) u_core (
    .opa (op_a),
    .opb (op_b),
    .fn  (alu_fn_e'(func_sel)),
    .y   (result)
  );

  assign bus_out    = drive_en ? result : '0;
  assign bus_out_en = drive_en;

  bus_cmp #(.WIDTH(WIDTH)) u_cmp (
    .bus_val (bus_in),
    .sel_gt  (cmp_sel),
    .lt_hit  (lt_hit),
    .gt_hit  (gt_hit),
    .cond    (cmp_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_flag <= 1'b0;
    end else if (ld_flag) begin
      cond_flag <= cmp_live;
    end
  end

endmodule

// File: rtl/alu_cmp_unit_chk.sv
module alu_cmp_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] bus_in,
  input logic             ld_a,
  input logic             ld_b,
  input logic             ld_flag,
  input logic             drive_en,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_out_en,
  input logic             cond_flag,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             cmp_live,
  input logic             lt_hit,
  input logic             gt_hit
);

  p_load_a_r5: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> (op_a == $past(bus_in)));

  p_load_b_r5: assert property (@(posedge clk) disable iff (rst)
    ld_b |=> (op_b == $past(bus_in)));

  p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(op_a));

  p_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
    !ld_b |=> $stable(op_b));

  p_drive_r6: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (bus_out_en && bus_out == result));

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_out_en |-> (bus_out == '0));

  p_tests_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(lt_hit && gt_hit));

  p_zero_neither_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_in == '0) |-> (!lt_hit && !gt_hit && !cmp_live));

  p_flag_capture_r9: assert property (@(posedge clk) disable iff (rst)
    ld_flag |=> (cond_flag == $past(cmp_live)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ld_flag |=> $stable(cond_flag));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!cond_flag && op_a == '0 && op_b == '0));

endmodule

bind alu_cmp_unit alu_cmp_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_in     (bus_in),
  .ld_a       (ld_a),
  .ld_b       (ld_b),
  .ld_flag    (ld_flag),
  .drive_en   (drive_en),
  .result     (result),
  .bus_out    (bus_out),
  .bus_out_en (bus_out_en),
  .cond_flag  (cond_flag),
  .op_a       (op_a),
  .op_b       (op_b),
  .cmp_live   (cmp_live),
  .lt_hit     (lt_hit),
  .gt_hit     (gt_hit)
);

// File: tb/alu_cmp_unit_test.sv
module alu_cmp_unit_test;

  localparam int W = 32;
  localparam int SRC_RESULT = 0;
  localparam int SRC_BUS    = 1;
  localparam int SRC_BUS_EN = 2;
  localparam int SRC_FLAG   = 3;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  tb_bus = '0;
  logic [W-1:0]  bus_in;
  logic          ld_a = 1'b0, ld_b = 1'b0, ld_flag = 1'b0;
  logic [1:0]    func_sel = 2'b00;
  logic          cmp_sel = 1'b0;
  logic          drive_en = 1'b0;
  logic [W-1:0]  result, bus_out;
  logic          bus_out_en, cond_flag;

  int total = 0;
  int fails = 0;
  bit done = 0;
  sb_item_t sbq[$];

  always #10 clk = ~clk;

  assign bus_in = drive_en ? bus_out : tb_bus;

  alu_cmp_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
    .ld_flag(ld_flag), .func_sel(func_sel), .cmp_sel(cmp_sel),
    .drive_en(drive_en), .result(result), .bus_out(bus_out),
    .bus_out_en(bus_out_en), .cond_flag(cond_flag)
  );

  // Monitor: pops every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.src)
        SRC_RESULT: act = result;
        SRC_BUS:    act = bus_out;
        SRC_BUS_EN: act = {31'b0, bus_out_en};
        default:    act = {31'b0, cond_flag};
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic model_cond(logic [31:0] v, logic gt);
    if (gt) return $signed(v) > 0;
    return $signed(v) < 0;
  endfunction

  task automatic expect_at_neg(int src, logic [31:0] exp, string tag);
    sbq.push_back('{src, exp, tag});
    @(negedge clk);
    #1;
  endtask

  task automatic load_ops(logic [31:0] a, logic [31:0] b);
    @(posedge clk); #1;
    tb_bus = a; ld_a = 1'b1;
    @(posedge clk); #1;
    ld_a = 1'b0; tb_bus = b; ld_b = 1'b1;
    @(posedge clk); #1;
    ld_b = 1'b0; tb_bus = '0;
  endtask

  task automatic check_fn(logic [1:0] fn, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    func_sel = fn;
    expect_at_neg(SRC_RESULT, exp, tag);
  endtask

  // Forces a value on the bus and pulses ld_flag for one edge.
  task automatic flag_from_bus(logic [31:0] v, logic sel, string tag);
    @(posedge clk); #1;
    tb_bus = v; cmp_sel = sel; ld_flag = 1'b1;
    @(posedge clk); #1;
    ld_flag = 1'b0; tb_bus = '0;
    expect_at_neg(SRC_FLAG, {31'b0, model_cond(v, sel)}, tag);
  endtask

  // Puts A-B on the bus through the unit itself, then captures the test.
  task automatic branch_test(logic [31:0] a, logic [31:0] b, logic sel, string tag);
    load_ops(a, b);
    @(posedge clk); #1;
    func_sel = 2'b01; drive_en = 1'b1; cmp_sel = sel; ld_flag = 1'b1;
    @(posedge clk); #1;
    drive_en = 1'b0; ld_flag = 1'b0;
    expect_at_neg(SRC_FLAG, {31'b0, model_cond(a - b, sel)}, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: reset state
    expect_at_neg(SRC_FLAG, 32'd0, "R10 flag after reset");
    expect_at_neg(SRC_RESULT, 32'd0, "R10 operands zero, sum");
    expect_at_neg(SRC_BUS_EN, 32'd0, "R6 no drive after reset");

    // R1 sum with wrap
    load_ops(32'h0000_1234, 32'h0000_0F0F);
    check_fn(2'b00, 32'h0000_2143, "R1 sum");
    load_ops(32'hFFFF_FFFF, 32'h0000_0002);
    check_fn(2'b00, 32'h0000_0001, "R1 sum wraps");
    // R2 difference
    load_ops(32'd5, 32'd9);
    check_fn(2'b01, 32'hFFFF_FFFC, "R2 diff negative");
    load_ops(32'h8000_0000, 32'd1);
    check_fn(2'b01, 32'h7FFF_FFFF, "R2 diff wraps");
    // R3 nand
    load_ops(32'hF0F0_FF00, 32'hFF00_F0F0);
    check_fn(2'b10, 32'h0FFF_0FFF, "R3 nand");
    // R4 increment, B ignored
    load_ops(32'hFFFF_FFFF, 32'h1234_5678);
    check_fn(2'b11, 32'h0000_0000, "R4 inc wraps");
    load_ops(32'h0000_0041, 32'hDEAD_BEEF);
    check_fn(2'b11, 32'h0000_0042, "R4 inc with B set");

    // R5: only B reloaded, A kept
    @(posedge clk); #1;
    tb_bus = 32'h0000_0100; ld_b = 1'b1;
    @(posedge clk); #1;
    ld_b = 1'b0; tb_bus = 32'hAAAA_AAAA;
    func_sel = 2'b00;
    expect_at_neg(SRC_RESULT, 32'h0000_0141, "R5 B alone loaded, A held");

    // R6 drive pair
    @(posedge clk); #1;
    drive_en = 1'b1;
    expect_at_neg(SRC_BUS, 32'h0000_0141, "R6 bus carries result");
    expect_at_neg(SRC_BUS_EN, 32'd1, "R6 enable high");
    drive_en = 1'b0;
    expect_at_neg(SRC_BUS, 32'd0, "R6 bus zero when idle");
    tb_bus = '0;

    // R7 / R8 from forced bus values
    flag_from_bus(32'h8000_0000, 1'b0, "R7 lt on MSB set");
    flag_from_bus(32'h7FFF_FFFF, 1'b0, "R7 lt clear on positive");
    flag_from_bus(32'h7FFF_FFFF, 1'b1, "R8 gt on positive");
    flag_from_bus(32'h0000_0000, 1'b1, "R8 gt clear on zero");
    flag_from_bus(32'h0000_0000, 1'b0, "R8 lt clear on zero");
    flag_from_bus(32'hFFFF_FFFF, 1'b1, "R8 gt clear on negative");

    // R9 hold: flag set, then bus changes without ld_flag
    flag_from_bus(32'h0000_0001, 1'b1, "R9 set flag");
    @(posedge clk); #1;
    tb_bus = 32'h0000_0000; cmp_sel = 1'b0;
    @(posedge clk); #1;
    tb_bus = 32'h8000_0000; cmp_sel = 1'b1;
    expect_at_neg(SRC_FLAG, 32'd1, "R9 flag held without strobe");
    tb_bus = '0;

    // R9 end to end: A-B put on the bus by the unit
    branch_test(32'd3, 32'd7, 1'b0, "R9 branch 3<7");
    branch_test(32'd3, 32'd7, 1'b1, "R9 branch not 3>7");
    branch_test(32'd9, 32'd2, 1'b1, "R9 branch 9>2");
    branch_test(32'd6, 32'd6, 1'b0, "R9 branch equal");
    branch_test(32'h8000_0000, 32'd1, 1'b0, "R9 overflow diff read by sign");

    // R10 reset mid run clears flag
    flag_from_bus(32'hFFFF_FFF0, 1'b0, "R7 set before reset");
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    func_sel = 2'b00;
    expect_at_neg(SRC_FLAG, 32'd0, "R10 flag cleared");
    expect_at_neg(SRC_RESULT, 32'd0, "R10 operands cleared");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule